// File: doc/BRIEF.md
# Broadcast-Sample Rotating-Coefficient Convolver

This block computes a one-dimensional convolution of a stream of signed samples with a short set of signed coefficients. A row of multiply-accumulate cells all see the same sample in the same cycle. The coefficients travel around a closed ring of registers, one cell further per accepted sample, while each cell's running sum stays in its own accumulator. One coefficient carries a marker bit. The cell that holds the marked coefficient adds its last product, places the finished sum on a shared result bus and starts again from zero.

A small controller has two states. In ST_FILL the block takes coefficients, first to last, on a shift-in port and ignores samples. The transition FILL_DONE (the last of the K coefficient writes) moves it to ST_RUN. There every valid sample is multiplied in and gives exactly one result one cycle later. The transition RELOAD (any coefficient write while in ST_RUN) sends it back to ST_FILL, discards all partial sums and counts that write as the first of a new set. Without a coefficient write, ST_FILL stays in ST_FILL (HOLD_FILL) and ST_RUN stays in ST_RUN (HOLD_RUN).

Top module: `bcast_ring_convolver`

## Requirements
- R1: After reset the block is in ST_FILL, `res_valid` is 0 and `res_data` is 0, and samples give no result until K coefficients have been written.
- R2: Each cycle with `load_en` high shifts `load_w` into the coefficient ring. Coefficients are written in order w1 first, wK last. The K-th write since entering ST_FILL enters ST_RUN, and samples offered earlier give no result.
- R3: In ST_RUN, a sample taken with `smp_valid` high gives `res_valid` high one cycle later. The n-th result since entering ST_RUN (n from 1) equals the sum over j=1..K of wj·x(n−K+j), where x(m) is the m-th sample taken and x(m)=0 for m<1.
- R4: Cycles with `smp_valid` low do not change the coefficient ring or the accumulators, so a stream with gaps gives the same results as the same stream without gaps.
- R5: A cell clears its accumulator in the cycle it emits, so every result after the first K still matches R3.
- R6: Results are exact over the full signed 8-bit range. The accumulator and `res_data` are 20-bit two's complement, so that −128·−128·3 = 49152 is carried without overflow.
- R7: A coefficient write in ST_RUN returns the block to ST_FILL and discards all partial sums. After the new set is complete, results again follow R3 with sample numbering restarted at 1.
- R8: When `load_en` and `smp_valid` are high in the same cycle, the coefficient write is taken and the sample is dropped, with no result.
- R9: `res_data` is 0 in every cycle in which `res_valid` is 0.
- R10: Exactly one coefficient in the ring carries the marker at all times, so exactly one cell completes per accepted sample. If several cells were marked, the lowest-index cell would drive the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Coefficient write strobe |
| load_w | input | 8 | Signed coefficient shifted in on a write |
| smp_valid | input | 1 | Sample strobe |
| smp_x | input | 8 | Signed sample, broadcast to all cells |
| res_valid | output | 1 | Result strobe, one cycle after an accepted sample |
| res_data | output | 20 | Signed convolution result, 0 when not valid |

## Verification
An ascending sample ramp with small distinct coefficients shows the coefficient order and the leading partial sums, because a swapped or misaligned coefficient changes every value. The same stream broken by idle gaps separates a real stall from a ring that keeps rotating. All-minimum coefficients and samples test sign extension and accumulator width. A reload in mid-stream and a write that coincides with a sample check that partial sums are discarded and that the write wins over the sample.

// File: rtl/bcconv_pkg.sv
package bcconv_pkg;
    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } conv_state_t;
endpackage

// File: rtl/conv_mac_cell.sv
module conv_mac_cell #(
    parameter int DW = 8,
    parameter int AW = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step,
    input  logic                 flush,
    input  logic                 tag,
    input  logic signed [DW-1:0] w,
    input  logic signed [DW-1:0] x,
    output logic signed [AW-1:0] sum_o
);
    localparam int PW = 2 * DW;

    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] prod_ext;
    logic signed [AW-1:0] acc;

    assign prod     = w * x;
    assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};
    assign sum_o    = acc + prod_ext;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (flush) begin
            acc <= '0;
        end else if (step) begin
            acc <= tag ? '0 : sum_o;
        end
    end

    // R5: a cell that emits restarts from zero
    a_r5_clear_after_emit: assert property (@(posedge clk) disable iff (!rst_n)
        (step && tag && !flush) |=> (acc == '0));

    // R4: no sample, no change
    a_r4_acc_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !flush) |=> $stable(acc));
endmodule

// File: rtl/conv_weight_ring.sv
module conv_weight_ring #(
    parameter int K  = 3,
    parameter int DW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rotate,
    input  logic                 fill,
    input  logic signed [DW-1:0] fill_w,
    output logic signed [DW-1:0] w_o [K],
    output logic [K-1:0]         tag_o
);
    localparam logic [K-1:0] HOME = {1'b1, {(K-1){1'b0}}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < K; c++) begin
                w_o[c] <= '0;
            end
            tag_o <= HOME;
        end else if (fill) begin
            for (int c = 0; c < K - 1; c++) begin
                w_o[c] <= w_o[c+1];
            end
            w_o[K-1] <= fill_w;
            tag_o    <= HOME;
        end else if (rotate) begin
            for (int c = 0; c < K; c++) begin
                w_o[c]   <= w_o[(c+1) % K];
                tag_o[c] <= tag_o[(c+1) % K];
            end
        end
    end

    // R10: exactly one marked coefficient
    a_r10_single_tag: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tag_o) == 1);

    // R3: coefficients advance one cell per accepted sample
    a_r3_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        (rotate && !fill) |=> (w_o[0] == $past(w_o[1])));

    // R4: ring frozen without a sample or a write
    a_r4_ring_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (!rotate && !fill) |=> ($stable(tag_o) && $stable(w_o[0])));
endmodule

// File: rtl/conv_bus_select.sv
module conv_bus_select #(
    parameter int K  = 3,
    parameter int AW = 20
) (
    input  logic [K-1:0]         tag_i,
    input  logic signed [AW-1:0] sum_i [K],
    output logic signed [AW-1:0] bus_o
);
    // Lowest index is scanned last, so it wins (R10)
    always_comb begin
        bus_o = '0;
        for (int c = K - 1; c >= 0; c--) begin
            if (tag_i[c]) begin
                bus_o = sum_i[c];
            end
        end
    end
endmodule

// File: rtl/bcast_ring_convolver.sv
module bcast_ring_convolver
    import bcconv_pkg::*;
#(
    parameter int NUM_CELLS = 3,
    parameter int SMP_W     = 8,
    parameter int ACC_W     = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_en,
    input  logic signed [SMP_W-1:0] load_w,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_x,
    output logic                    res_valid,
    output logic signed [ACC_W-1:0] res_data
);
    localparam int CNT_W = $clog2(NUM_CELLS + 1);
    localparam logic [CNT_W-1:0] LAST_LOAD = CNT_W'(NUM_CELLS - 1);

    conv_state_t          state_q, state_d;
    logic [CNT_W-1:0]     cnt_q, cnt_d;
    logic                 step;
    logic signed [SMP_W-1:0] w_v   [NUM_CELLS];
    logic [NUM_CELLS-1:0]    tag_v;
    logic signed [ACC_W-1:0] sum_v [NUM_CELLS];
    logic signed [ACC_W-1:0] bus;

    assign step = (state_q == ST_RUN) && smp_valid && !load_en;

    // next state: FILL_DONE, RELOAD, HOLD_FILL, HOLD_RUN
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_FILL: begin
                if (load_en) begin
                    if (cnt_q == LAST_LOAD) begin
                        state_d = ST_RUN;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            ST_RUN: begin
                if (load_en) begin
                    state_d = ST_FILL;
                    cnt_d   = CNT_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= step;
            res_data  <= step ? bus : '0;
        end
    end

    conv_weight_ring #(.K(NUM_CELLS), .DW(SMP_W)) u_ring (
        .clk    (clk),
        .rst_n  (rst_n),
        .rotate (step),
        .fill   (load_en),
        .fill_w (load_w),
        .w_o    (w_v),
        .tag_o  (tag_v)
    );

    for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
        conv_mac_cell #(.DW(SMP_W), .AW(ACC_W)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .step  (step),
            .flush (load_en),
            .tag   (tag_v[c]),
            .w     (w_v[c]),
            .x     (smp_x),
            .sum_o (sum_v[c])
        );
    end

    conv_bus_select #(.K(NUM_CELLS), .AW(ACC_W)) u_sel (
        .tag_i (tag_v),
        .sum_i (sum_v),
        .bus_o (bus)
    );

    // R1 / R2: nothing emitted while filling
    a_r1_quiet_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |=> !res_valid);

    // R3: each accepted sample gives a result next cycle
    a_r3_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && smp_valid && !load_en) |=> res_valid);

    // R8: a write always beats a sample
    a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> !res_valid);

    // R9: bus is zero when not valid
    a_r9_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_data == '0));

    // R7: a write in run always goes back to fill
    a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && load_en) |=> (state_q == ST_FILL));
endmodule

// File: tb/bcast_ring_convolver_tb_top.sv
module bcast_ring_convolver_tb_top;
    localparam int K = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_en = 1'b0;
    logic signed [7:0] load_w = '0;
    logic              smp_valid = 1'b0;
    logic signed [7:0] smp_x = '0;
    logic              res_valid;
    logic signed [19:0] res_data;

    int n_run = 0;
    int n_fail = 0;
    int n_sent = 0;
    int n_seen = 0;
    int wt [K];
    int xs [$];
    bit done = 1'b0;

    always #4 clk = ~clk;

    bcast_ring_convolver dut_i (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_w(load_w),
        .smp_valid(smp_valid), .smp_x(smp_x),
        .res_valid(res_valid), .res_data(res_data)
    );

    task automatic check(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model();
        int n = xs.size();
        int s = 0;
        for (int j = 1; j <= K; j++) begin
            int idx = n - K + j;
            if (idx >= 1) s += wt[j-1] * xs[idx-1];
        end
        return s;
    endfunction

    task automatic load_one(int w);
        load_en = 1'b1;
        load_w  = 8'(w);
        @(negedge clk);
        load_en = 1'b0;
        check("R2 no result on write", int'(res_valid), 0);
    endtask

    task automatic load_set(int a, int b, int c);
        wt[0] = a; wt[1] = b; wt[2] = c;
        xs.delete();
        load_one(a); load_one(b); load_one(c);
    endtask

    task automatic send(int x, string req);
        smp_valid = 1'b1;
        smp_x     = 8'(x);
        @(negedge clk);
        smp_valid = 1'b0;
        xs.push_back(x);
        n_sent++;
        if (res_valid) n_seen++;
        check(req, int'(res_valid), 1);
        check(req, int'(res_data), model());
    endtask

    task automatic send_ignored(int x, string req);
        smp_valid = 1'b1;
        smp_x     = 8'(x);
        @(negedge clk);
        smp_valid = 1'b0;
        check(req, int'(res_valid), 0);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R4 no result when idle", int'(res_valid), 0);
            check("R9 zero bus when idle", int'(res_data), 0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset valid", int'(res_valid), 0);
        check("R1 reset data", int'(res_data), 0);
    endtask

    task automatic t_fill_gate();
        send_ignored(9, "R1 sample before any write");
        load_one(1);
        load_one(2);
        send_ignored(7, "R2 sample with partial set");
        wt[0] = 1; wt[1] = 2; wt[2] = 3;
        xs.delete();
        load_one(3);
    endtask

    task automatic t_ramp();
        for (int i = 1; i <= 8; i++) begin
            send(i, (i <= K) ? "R3 leading sums" : "R5 steady sums after clear");
        end
    endtask

    task automatic t_gaps();
        load_set(2, -1, 4);
        send(5, "R7 fresh start");
        idle(2);
        send(-3, "R4 after gap");
        send(7, "R4 back to back");
        idle(1);
        send(11, "R4 after gap");
        send(-20, "R4 steady");
        idle(3);
        send(6, "R4 steady after long gap");
    endtask

    task automatic t_extreme();
        load_set(-128, -128, -128);
        for (int i = 0; i < 4; i++) send(-128, "R6 min times min");
        load_set(127, -128, 127);
        send(-128, "R6 mixed sign");
        send(127, "R6 mixed sign");
        send(-128, "R6 mixed sign");
        send(127, "R6 mixed sign");
    endtask

    task automatic t_reload_mid();
        load_set(1, 1, 1);
        send(5, "R7 before reload");
        send(6, "R7 before reload");
        load_set(10, 20, 30);
        send(2, "R7 partial sums discarded");
        send(3, "R7 partial sums discarded");
        send(4, "R7 full sum after reload");
    endtask

    task automatic t_load_priority();
        load_en   = 1'b1;
        load_w    = 8'(4);
        smp_valid = 1'b1;
        smp_x     = 8'(50);
        @(negedge clk);
        load_en   = 1'b0;
        smp_valid = 1'b0;
        check("R8 write beats sample", int'(res_valid), 0);
        wt[0] = 4;
        xs.delete();
        load_one(5);
        wt[1] = 5;
        load_one(6);
        wt[2] = 6;
        send(3, "R8 dropped sample not counted");
        send(2, "R8 dropped sample not counted");
    endtask

    initial begin
        t_reset();
        t_fill_gate();
        t_ramp();
        t_gaps();
        t_extreme();
        t_reload_mid();
        t_load_priority();
        check("R10 one result per sample", n_seen, n_sent);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule